// File: doc/BRIEF.md
# External Interrupt Request Detector

This block watches eight external interrupt pins and turns their activity into request bits for a downstream priority arbiter. Every pin is first brought into the clock domain through a synchronizer chain. A 2-bit sense code per pin selects whether the pin is observed as a level (active low or active high) or as an edge (falling or rising). The result is held in a pending register that software can read over a small register port.

Level-sensed pins simply mirror the synchronized pin state. Edge-sensed pins latch an event, which stays pending until software clears it. The clear protocol has two steps: the bit must first be read back as 1, and then a 0 must be written to it. A new edge that lands in the same cycle as a clear wins.

Edge detection runs on the pin level after the sense polarity has been applied. A rewrite of the sense register can therefore flip that normalized level while the pin itself stays still, and so record an event that never happened on the wire. Software removes such events with the same read-then-write-zero sequence. Two further registers hold a 4-bit priority per pin for the arbiter. A request is presented to the arbiter only when its priority is nonzero.

Top module: `irq_request_detector`

## Requirements
- R1: After a synchronous active-low reset, the pending register reads 0 and `req_o` is 0. The sense register reads 16'hAAAA (rising edge on every pin), and both priority registers read 0.
- R2: Each pin passes through a two-flop synchronizer. A level change applied before rising clock edge k is visible in the pending bit after edge k+2, and not after edge k+1.
- R3: The sense code for pin i sits at sense-register bits [2i+1:2i]. Code 00 means active-low level and 11 means active-high level. In these two modes the pending bit equals the active state of the synchronized pin.
- R4: Code 01 sets the pending bit on a falling edge and code 10 sets it on a rising edge. An edge of the opposite direction leaves the bit unchanged.
- R5: In a level mode, writes to the pending register have no effect on that bit.
- R6: In an edge mode, writing 0 to a pending bit clears it only if a read of the pending register (address 0) returned 1 for that bit since the bit was last set. Bits written with 1 are left unchanged.
- R7: Writing 1 to a pending bit never sets it.
- R8: An edge event that arrives in the same cycle as a clear of that bit leaves the bit set. The bit must then be read as 1 again before a write of 0 can clear it.
- R9: A rewrite of the sense register that makes a pin's polarity-adjusted level go from inactive to active, while the pin is in an edge mode, sets that pending bit. The read-then-write-zero sequence clears it.
- R10: The priority of pins 0–3 is held at address 2 and that of pins 4–7 at address 3, with pin i at bits [4(i mod 4)+3 : 4(i mod 4)]. `prio_o[4i+3:4i]` carries the priority of pin i.
- R11: `req_o[i]` is the pending bit of pin i gated by a nonzero priority. A priority of 0 keeps the request low while the pending bit stays visible in the register.
- R12: The read data returns pending bits at address 0 (upper byte zero), the sense register at address 1, and the two priority registers at addresses 2 and 3. It is combinational from the current address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_pin_i | input | 8 | Asynchronous external interrupt pins, bit i is pin i |
| bus_wr_i | input | 1 | Register write strobe |
| bus_rd_i | input | 1 | Register read strobe (arms clears on address 0) |
| bus_addr_i | input | 2 | Register address |
| bus_wdata_i | input | 16 | Write data |
| bus_rdata_o | output | 16 | Read data, combinational from bus_addr_i |
| req_o | output | 8 | Requests to the arbiter, pending gated by nonzero priority |
| prio_o | output | 32 | Per-pin priority, pin i at bits [4i+3:4i] |

## Verification
The bench uses the default build: eight pins, 4-bit priorities, a 16-bit data bus and a two-stage synchronizer. With eight pins, every one of the 256 pin patterns can be swept in both level modes and in both edge modes. The expected pending value is derived arithmetically from the pattern and the sense code. The short synchronizer also makes exact cycle-placement tests practical: a clear can be made to collide with a fresh edge on the same clock edge, and sense rewrites can produce spurious events whose expected bits follow from the old and new polarities.

// File: rtl/irq_det_pkg.sv
// Package: shared constants for the external interrupt request detector.
// Assumes a two-bit register address and a two-bit sense code per pin.
package irq_det_pkg;
    // Sense codes: bit 1 picks polarity (1 = high/rising), equal bits mean level.
    localparam logic [1:0] SNS_LOW  = 2'b00;
    localparam logic [1:0] SNS_FALL = 2'b01;
    localparam logic [1:0] SNS_RISE = 2'b10;
    localparam logic [1:0] SNS_HIGH = 2'b11;

    // Register addresses.
    localparam logic [1:0] ADDR_PEND    = 2'd0;
    localparam logic [1:0] ADDR_SENSE   = 2'd1;
    localparam logic [1:0] ADDR_PRIO_LO = 2'd2;
    localparam logic [1:0] ADDR_PRIO_HI = 2'd3;
endpackage

// File: rtl/irq_sync.sv
// Module: irq_sync
// Multi-stage synchronizer for a vector of asynchronous inputs.
// Assumes each bit is independent (no multi-bit coherency is needed).
module irq_sync #(
    parameter int unsigned WIDTH  = 8,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    logic [WIDTH-1:0] stg [STAGES];

    // Shift the input through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < STAGES; k++) stg[k] <= '0;
        end else begin
            stg[0] <= d_i;
            for (int k = 1; k < STAGES; k++) stg[k] <= stg[k-1];
        end
    end

    assign q_o = stg[STAGES-1];

    AST_SYNC_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> stg[0] == $past(d_i)); // R2

    for (genvar k = 1; k < STAGES; k++) begin : gen_chk
        AST_SYNC_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
            $past(rst_n) |-> stg[k] == $past(stg[k-1])); // R2
    end
endmodule

// File: rtl/irq_pin_cell.sv
// Module: irq_pin_cell
// Pending-bit logic for one pin: polarity, level/edge sense, and the
// read-then-write-zero clear. Assumes pin_sync_i is already synchronous.
module irq_pin_cell
    import irq_det_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pin_sync_i,
    input  logic [1:0] sense_i,
    input  logic       rd_hit_i,
    input  logic       wr_hit_i,
    input  logic       wbit_i,
    output logic       pend_o
);
    logic is_level;
    logic invert;
    logic active;
    logic active_q;
    logic set_ev;
    logic clr_fire;
    logic pend_q;
    logic armed_q;

    // Decode sense code into level/edge and polarity.
    always_comb begin
        is_level = (sense_i == SNS_LOW) || (sense_i == SNS_HIGH);
        invert   = (sense_i == SNS_LOW) || (sense_i == SNS_FALL);
        active   = pin_sync_i ^ invert;
        set_ev   = !is_level && active && !active_q;
        clr_fire = wr_hit_i && !wbit_i && armed_q;
    end

    // Track the polarity-adjusted level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) active_q <= 1'b0;
        else        active_q <= active;
    end

    // Update pending bit and its read-arm flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q  <= 1'b0;
            armed_q <= 1'b0;
        end else if (is_level) begin
            pend_q  <= active;
            armed_q <= 1'b0;
        end else begin
            pend_q  <= set_ev || (pend_q && !clr_fire);
            armed_q <= clr_fire ? 1'b0 : (armed_q || (rd_hit_i && pend_q));
        end
    end

    assign pend_o = pend_q;

    AST_LEVEL_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(is_level)) |-> pend_q == $past(active)); // R5

    AST_CLR_NEEDS_ARM: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(is_level) && $past(pend_q) && !pend_q)
        |-> $past(wr_hit_i && !wbit_i && armed_q)); // R6

    AST_NO_WRITE_SET: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(is_level) && !$past(pend_q) && pend_q)
        |-> $past(active && !active_q)); // R7

    AST_EDGE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(set_ev)) |-> pend_q); // R8
endmodule

// File: rtl/irq_cfg_regs.sv
// Module: irq_cfg_regs
// Sense and priority registers plus the read-data multiplexer.
// Assumes the sense field and each priority half fit the data width.
module irq_cfg_regs
    import irq_det_pkg::*;
#(
    parameter int unsigned NUM_PINS = 8,
    parameter int unsigned PRIO_W   = 4,
    parameter int unsigned DATA_W   = 16,
    localparam int unsigned SENSE_W   = 2 * NUM_PINS,
    localparam int unsigned PRIO_BITS = PRIO_W * NUM_PINS,
    localparam int unsigned HALF      = PRIO_BITS / 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_i,
    input  logic [1:0]           addr_i,
    input  logic [DATA_W-1:0]    wdata_i,
    input  logic [NUM_PINS-1:0]  pend_i,
    output logic [SENSE_W-1:0]   sense_o,
    output logic [PRIO_BITS-1:0] prio_o,
    output logic [DATA_W-1:0]    rdata_o
);
    logic [SENSE_W-1:0]   sense_q;
    logic [PRIO_BITS-1:0] prio_q;

    // Register writes; sense resets to rising edge on every pin.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sense_q <= {NUM_PINS{SNS_RISE}};
            prio_q  <= '0;
        end else if (wr_i) begin
            case (addr_i)
                ADDR_SENSE:   sense_q <= wdata_i[SENSE_W-1:0];
                ADDR_PRIO_LO: prio_q[HALF-1:0] <= wdata_i[HALF-1:0];
                ADDR_PRIO_HI: prio_q[PRIO_BITS-1:HALF] <= wdata_i[HALF-1:0];
                default: ;
            endcase
        end
    end

    // Combinational read multiplexer.
    always_comb begin
        rdata_o = '0;
        case (addr_i)
            ADDR_PEND:    rdata_o[NUM_PINS-1:0] = pend_i;
            ADDR_SENSE:   rdata_o[SENSE_W-1:0]  = sense_q;
            ADDR_PRIO_LO: rdata_o[HALF-1:0]     = prio_q[HALF-1:0];
            ADDR_PRIO_HI: rdata_o[HALF-1:0]     = prio_q[PRIO_BITS-1:HALF];
            default:      rdata_o = '0;
        endcase
    end

    assign sense_o = sense_q;
    assign prio_o  = prio_q;

    AST_PRIO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(wr_i)) |-> $stable(prio_q)); // R10

    AST_SENSE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !($past(wr_i) && $past(addr_i) == ADDR_SENSE))
        |-> $stable(sense_q)); // R9
endmodule

// File: rtl/irq_request_detector.sv
// Module: irq_request_detector (top)
// Synchronizes external interrupt pins, senses them per pin, keeps the
// pending register and exposes priorities and gated requests to an arbiter.
// Assumes a single clock domain for the register port.
module irq_request_detector
    import irq_det_pkg::*;
#(
    parameter int unsigned NUM_PINS    = 8,
    parameter int unsigned PRIO_W      = 4,
    parameter int unsigned DATA_W      = 16,
    parameter int unsigned SYNC_STAGES = 2,
    localparam int unsigned PRIO_BITS  = PRIO_W * NUM_PINS
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_PINS-1:0]  irq_pin_i,
    input  logic                 bus_wr_i,
    input  logic                 bus_rd_i,
    input  logic [1:0]           bus_addr_i,
    input  logic [DATA_W-1:0]    bus_wdata_i,
    output logic [DATA_W-1:0]    bus_rdata_o,
    output logic [NUM_PINS-1:0]  req_o,
    output logic [PRIO_BITS-1:0] prio_o
);
    localparam int unsigned SENSE_W = 2 * NUM_PINS;

    logic [NUM_PINS-1:0]  pin_sync;
    logic [NUM_PINS-1:0]  pend;
    logic [SENSE_W-1:0]   sense;
    logic [PRIO_BITS-1:0] prio;
    logic                 rd_hit;
    logic                 wr_hit;

    irq_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (irq_pin_i),
        .q_o   (pin_sync)
    );

    irq_cfg_regs #(.NUM_PINS(NUM_PINS), .PRIO_W(PRIO_W), .DATA_W(DATA_W)) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (bus_wr_i),
        .addr_i  (bus_addr_i),
        .wdata_i (bus_wdata_i),
        .pend_i  (pend),
        .sense_o (sense),
        .prio_o  (prio),
        .rdata_o (bus_rdata_o)
    );

    // Decode accesses to the pending register.
    assign rd_hit = bus_rd_i && (bus_addr_i == ADDR_PEND);
    assign wr_hit = bus_wr_i && (bus_addr_i == ADDR_PEND);

    for (genvar i = 0; i < NUM_PINS; i++) begin : gen_pin
        irq_pin_cell u_cell (
            .clk        (clk),
            .rst_n      (rst_n),
            .pin_sync_i (pin_sync[i]),
            .sense_i    (sense[2*i +: 2]),
            .rd_hit_i   (rd_hit),
            .wr_hit_i   (wr_hit),
            .wbit_i     (bus_wdata_i[i]),
            .pend_o     (pend[i])
        );
        // Gate the request by a nonzero priority.
        assign req_o[i] = pend[i] && (prio[PRIO_W*i +: PRIO_W] != '0);
    end

    assign prio_o = prio;
endmodule

// File: tb/tb_irq_request_detector.sv
`timescale 1ns/1ps
module tb_irq_request_detector;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [7:0]  pins;
    logic        wr, rd;
    logic [1:0]  addr;
    logic [15:0] wdata;
    logic [15:0] rdata;
    logic [7:0]  req;
    logic [31:0] prio;
    int total = 0;
    int bad   = 0;
    bit done  = 0;

    irq_request_detector dut (
        .clk(clk), .rst_n(rst_n), .irq_pin_i(pins), .bus_wr_i(wr), .bus_rd_i(rd),
        .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
        .req_o(req), .prio_o(prio)
    );

    always #10 clk = ~clk;

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic step(int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic bus_write(logic [1:0] a, logic [15:0] d);
        wr = 1'b1; addr = a; wdata = d;
        step(1);
        wr = 1'b0;
    endtask

    task automatic bus_read(logic [1:0] a, output logic [15:0] d);
        rd = 1'b1; addr = a;
        #1 d = rdata;
        step(1);
        rd = 1'b0;
    endtask

    task automatic clear_all();
        logic [15:0] d;
        bus_read(2'd0, d);
        bus_write(2'd0, 16'h0000);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [15:0] d;
        logic [7:0]  exp;
        rst_n = 1'b0; pins = '0; wr = 0; rd = 0; addr = '0; wdata = '0;
        step(3);
        rst_n = 1'b1;
        step(1);

        // R1 / R12: reset state and read mux
        bus_read(2'd0, d); chk("R1 pend", d, 16'h0000);
        chk("R1 req", req, 8'h00);
        bus_read(2'd1, d); chk("R1 R12 sense", d, 16'hAAAA);
        bus_read(2'd2, d); chk("R1 prio lo", d, 16'h0000);
        bus_read(2'd3, d); chk("R1 prio hi", d, 16'h0000);

        // R10: priority layout
        bus_write(2'd2, 16'h4321);
        bus_write(2'd3, 16'h8765);
        chk("R10 prio_o", prio, 32'h87654321);
        bus_read(2'd2, d); chk("R10 R12 lo", d, 16'h4321);
        bus_read(2'd3, d); chk("R10 R12 hi", d, 16'h8765);
        for (int i = 0; i < 8; i++)
            chk("R10 pin prio", prio[4*i +: 4], 32'(i + 1));
        bus_write(2'd2, 16'h1111);
        bus_write(2'd3, 16'h1111);

        // R2: synchronizer latency in active-high level mode
        bus_write(2'd1, 16'hFFFF);
        pins = 8'h00; step(4);
        pins = 8'hFF;
        step(2); chk("R2 not yet", req, 8'h00);
        step(1); chk("R2 visible", req, 8'hFF);

        // R3: level sweeps, high then low
        for (int p = 0; p < 256; p++) begin
            pins = p[7:0]; step(3);
            bus_read(2'd0, d); chk("R3 high level", d, {8'h00, p[7:0]});
            chk("R3 R11 req", req, p[7:0]);
        end
        bus_write(2'd1, 16'h0000);
        for (int p = 0; p < 256; p++) begin
            pins = p[7:0]; step(3);
            bus_read(2'd0, d); chk("R3 low level", d, {8'h00, ~p[7:0]});
        end

        // R5: writes ignored in level mode
        bus_write(2'd1, 16'hFFFF);
        pins = 8'hA5; step(3);
        bus_read(2'd0, d);
        bus_write(2'd0, 16'h0000);
        bus_read(2'd0, d); chk("R5 write0 ignored", d, 16'h00A5);
        pins = 8'h00; step(3);
        bus_write(2'd0, 16'h00FF);
        bus_read(2'd0, d); chk("R5 write1 ignored", d, 16'h0000);

        // R4: rising edge sweep
        bus_write(2'd1, 16'hAAAA);
        step(4); clear_all();
        for (int p = 0; p < 256; p++) begin
            pins = p[7:0]; step(3);
            bus_read(2'd0, d); chk("R4 rising set", d, {8'h00, p[7:0]});
            pins = 8'h00; step(4);
            bus_read(2'd0, d); chk("R4 falling ignored", d, {8'h00, p[7:0]});
            bus_write(2'd0, 16'h0000);
            bus_read(2'd0, d); chk("R4 R6 cleared", d, 16'h0000);
        end

        // R4: falling edge sweep
        pins = 8'hFF; step(4);
        bus_write(2'd1, 16'h5555);
        step(2); clear_all();
        bus_read(2'd0, d); chk("R4 falling start", d, 16'h0000);
        for (int p = 0; p < 256; p++) begin
            pins = ~p[7:0]; step(3);
            bus_read(2'd0, d); chk("R4 falling set", d, {8'h00, p[7:0]});
            pins = 8'hFF; step(4);
            bus_read(2'd0, d); chk("R4 rising ignored", d, {8'h00, p[7:0]});
            bus_write(2'd0, 16'h0000);
            bus_read(2'd0, d); chk("R4 R6 cleared f", d, 16'h0000);
        end

        // R6: clear protocol details (rising mode, watch req)
        bus_write(2'd1, 16'hAAAA);
        pins = 8'h00; step(4); clear_all();
        pins = 8'h3C; step(3); pins = 8'h00; step(3);
        bus_write(2'd0, 16'h0000);
        chk("R6 no read no clear", req, 8'h3C);
        bus_read(2'd0, d);
        bus_write(2'd0, 16'h00F0);
        chk("R6 only zero bits clear", req, 8'h30);
        bus_write(2'd0, 16'h0000);
        chk("R6 armed rest cleared", req, 8'h00);
        pins = 8'h01; step(3); pins = 8'h00; step(3);
        clear_all();
        chk("R6 cleared once", req, 8'h00);
        pins = 8'h01; step(3); pins = 8'h00; step(3);
        bus_write(2'd0, 16'h0000);
        chk("R6 rearm needed after new set", req, 8'h01);
        clear_all();

        // R7: writing 1 never sets
        bus_write(2'd0, 16'h00FF);
        bus_read(2'd0, d); chk("R7 write1 no set", d, 16'h0000);

        // R8: edge collides with clear
        pins = 8'h01; step(3); pins = 8'h00; step(3);
        bus_read(2'd0, d); chk("R8 setup", d, 16'h0001);
        pins = 8'h01; step(2);
        bus_write(2'd0, 16'h0000);
        chk("R8 edge wins", req, 8'h01);
        bus_write(2'd0, 16'h0000);
        chk("R8 disarmed", req, 8'h01);
        pins = 8'h00; step(3); clear_all();

        // R9: spurious events from sense rewrite
        pins = 8'h0F; step(4); clear_all();
        bus_write(2'd1, 16'h5555); step(2);
        exp = (~pins) & ~pins;
        bus_read(2'd0, d); chk("R9 rise->fall spurious", d, {8'h00, exp});
        bus_write(2'd0, 16'h0000);
        bus_read(2'd0, d); chk("R9 cleared", d, 16'h0000);
        bus_write(2'd1, 16'hAAAA); step(2);
        exp = pins & ~(~pins);
        bus_read(2'd0, d); chk("R9 fall->rise spurious", d, {8'h00, exp});
        bus_write(2'd0, 16'h0000);
        bus_read(2'd0, d); chk("R9 cleared again", d, 16'h0000);

        // R11: zero priority masks request only
        bus_write(2'd2, 16'h0321);
        bus_write(2'd3, 16'h8765);
        bus_write(2'd1, 16'hFFFF);
        pins = 8'hFF; step(3);
        chk("R11 masked req", req, 8'hF7);
        bus_read(2'd0, d); chk("R11 pend visible", d, 16'h00FF);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule